// File: doc/BRIEF.md
# Memory Write Integrity CRC Accumulator

This block keeps a running 32-bit CRC over the host writes that land in two memories: an instruction store and a data store. Each write that counts is turned into a 48-bit record made of a store-select flag, the zero-extended word index and the 32-bit word written. That record is folded into the stored CRC in a single cycle. Software can later read the CRC and compare it against a value it computed itself, to confirm that the memories were loaded correctly.

Only full-word host writes are counted. Writes with partial byte enables are dropped. Any cycle in which the processor core owns the memories is also dropped. The host can load the CRC register directly; loading zero gives the usual starting value.

Top module: `memload_crc`

## Requirements
- R1: A record is 48 bits wide. Bit 47 is the store flag: 1 for the instruction store, 0 for the data store. Bits 46:32 hold the 10-bit word index, zero-extended to 15 bits. Bits 31:0 hold the 32-bit write data.
- R2: A counted write replaces the CRC with the reflected CRC-32 of the record, using polynomial 0xEDB88320. The record is processed one bit at a time, bit 0 first, for all 48 bits. For each bit: feedback = crc[0] XOR record bit; then crc = crc >> 1; then, if feedback is 1, crc ^= 0xEDB88320. There is no final XOR.
- R3: A memory request counts only when its 4-bit byte mask equals 4'hF. A request with any other mask value leaves the CRC unchanged.
- R4: While `core_owns_i` is high, no memory request changes the CRC.
- R5: When `imem_req_i` is high, the record takes its index and data from the instruction-store inputs and its flag is set to 1. This holds even if the data store is also requesting. When `imem_req_i` is low, the data-store inputs are used and the flag is 0. The write counts if either request is qualified by R3 and R4.
- R6: When `crc_we_i` is high, the CRC is loaded with `crc_wdata_i`. Any memory record in that same cycle is discarded. Writing 0 clears the CRC to 32'h00000000.
- R7: An active-low `rst_ni` clears the CRC to 32'h00000000 asynchronously, without waiting for a clock edge.
- R8: An update, whether from a record or from a host write, appears on `crc_o` after the first rising clock edge that samples it. Cycles with no update leave `crc_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| core_owns_i | input | 1 | Core currently owns the memories |
| imem_req_i | input | 1 | Host request to the instruction store |
| imem_mask_i | input | 4 | Byte enables for the instruction-store write |
| imem_idx_i | input | 10 | Word index in the instruction store |
| imem_wdata_i | input | 32 | Instruction-store write data |
| dmem_req_i | input | 1 | Host request to the data store |
| dmem_mask_i | input | 4 | Byte enables for the data-store write |
| dmem_idx_i | input | 10 | Word index in the data store |
| dmem_wdata_i | input | 32 | Data-store write data |
| crc_we_i | input | 1 | Host load of the CRC register |
| crc_wdata_i | input | 32 | Value for the host load |
| crc_o | output | 32 | Current CRC value |

## Verification
The CRC register is the only state in the block. A wrong fold, a wrong record layout or a wrongly qualified write therefore shows on `crc_o` at the very next clock edge. Every later record chains on top of that wrong value, so the error never goes away until the next host load or reset. The bench compares `crc_o` against a bit-serial model on every cycle, which catches the first wrong cycle exactly. Directed cycles cover partial masks, core ownership, both stores requesting at once, a host load colliding with a record, and an asynchronous reset in the middle of a run.

// File: rtl/memcrc_pkg.sv
package memcrc_pkg;
    localparam int DATA_W    = 32;
    localparam int MASK_W    = DATA_W / 8;
    localparam int IDX_W     = 10;
    localparam int IDX_EXT_W = 15;
    localparam int CRC_W     = 32;
    localparam int REC_W     = 1 + IDX_EXT_W + DATA_W;
    localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB88320;

    typedef struct packed {
        logic                 flag;
        logic [IDX_EXT_W-1:0] idx;
        logic [DATA_W-1:0]    data;
    } rec_t;

    typedef struct packed {
        logic [CRC_W-1:0] crc;
    } crc_state_t;
endpackage

// File: rtl/memcrc_qualify.sv
module memcrc_qualify
    import memcrc_pkg::*;
(
    input  logic              core_owns_i,
    input  logic              imem_req_i,
    input  logic [MASK_W-1:0] imem_mask_i,
    input  logic              dmem_req_i,
    input  logic [MASK_W-1:0] dmem_mask_i,
    output logic              valid_o
);
    localparam logic [MASK_W-1:0] FULL = {MASK_W{1'b1}};

    logic imem_full, dmem_full;

    always_comb begin
        imem_full = imem_req_i && (imem_mask_i == FULL);
        dmem_full = dmem_req_i && (dmem_mask_i == FULL);
        valid_o   = !core_owns_i && (imem_full || dmem_full);
    end
endmodule

// File: rtl/memcrc_record.sv
module memcrc_record
    import memcrc_pkg::*;
(
    input  logic              imem_req_i,
    input  logic [IDX_W-1:0]  imem_idx_i,
    input  logic [DATA_W-1:0] imem_wdata_i,
    input  logic [IDX_W-1:0]  dmem_idx_i,
    input  logic [DATA_W-1:0] dmem_wdata_i,
    output rec_t              rec_o
);
    localparam int PAD_W = IDX_EXT_W - IDX_W;

    always_comb begin
        rec_o.flag = imem_req_i;
        if (imem_req_i) begin
            rec_o.idx  = {{PAD_W{1'b0}}, imem_idx_i};
            rec_o.data = imem_wdata_i;
        end else begin
            rec_o.idx  = {{PAD_W{1'b0}}, dmem_idx_i};
            rec_o.data = dmem_wdata_i;
        end
    end
endmodule

// File: rtl/memcrc_fold.sv
module memcrc_fold
    import memcrc_pkg::*;
#(
    parameter int               W_CRC = CRC_W,
    parameter int               W_REC = REC_W,
    parameter logic [W_CRC-1:0] POLY  = CRC_POLY
) (
    input  logic [W_CRC-1:0] crc_i,
    input  logic [W_REC-1:0] rec_i,
    output logic [W_CRC-1:0] crc_o
);
    logic [W_CRC-1:0] chain [0:W_REC];

    assign chain[0] = crc_i;

    for (genvar i = 0; i < W_REC; i++) begin : g_bit
        logic fb;
        assign fb          = chain[i][0] ^ rec_i[i];
        assign chain[i+1]  = (chain[i] >> 1) ^ (fb ? POLY : '0);
    end

    assign crc_o = chain[W_REC];
endmodule

// File: rtl/memload_crc.sv
module memload_crc
    import memcrc_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              core_owns_i,
    input  logic              imem_req_i,
    input  logic [MASK_W-1:0] imem_mask_i,
    input  logic [IDX_W-1:0]  imem_idx_i,
    input  logic [DATA_W-1:0] imem_wdata_i,
    input  logic              dmem_req_i,
    input  logic [MASK_W-1:0] dmem_mask_i,
    input  logic [IDX_W-1:0]  dmem_idx_i,
    input  logic [DATA_W-1:0] dmem_wdata_i,
    input  logic              crc_we_i,
    input  logic [CRC_W-1:0]  crc_wdata_i,
    output logic [CRC_W-1:0]  crc_o
);
    crc_state_t       st_d, st_q;
    logic             rec_valid;
    rec_t             rec;
    logic [CRC_W-1:0] crc_next;

    memcrc_qualify u_qualify (
        .core_owns_i (core_owns_i),
        .imem_req_i  (imem_req_i),
        .imem_mask_i (imem_mask_i),
        .dmem_req_i  (dmem_req_i),
        .dmem_mask_i (dmem_mask_i),
        .valid_o     (rec_valid)
    );

    memcrc_record u_record (
        .imem_req_i   (imem_req_i),
        .imem_idx_i   (imem_idx_i),
        .imem_wdata_i (imem_wdata_i),
        .dmem_idx_i   (dmem_idx_i),
        .dmem_wdata_i (dmem_wdata_i),
        .rec_o        (rec)
    );

    memcrc_fold #(
        .W_CRC (CRC_W),
        .W_REC (REC_W),
        .POLY  (CRC_POLY)
    ) u_fold (
        .crc_i (st_q.crc),
        .rec_i (rec),
        .crc_o (crc_next)
    );

    always_comb begin
        st_d = st_q;
        if (crc_we_i) begin
            st_d.crc = crc_wdata_i;
        end else if (rec_valid) begin
            st_d.crc = crc_next;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign crc_o = st_q.crc;

    // Host load wins over any record in the same cycle.
    assert_host_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        crc_we_i |=> crc_o == $past(crc_wdata_i));

    // Core ownership blocks all record updates.
    assert_core_skip_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (core_owns_i && !crc_we_i) |=> $stable(crc_o));

    // Partial byte masks never advance the CRC.
    assert_partial_skip_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!crc_we_i && (!imem_req_i || imem_mask_i != 4'hF)
                   && (!dmem_req_i || dmem_mask_i != 4'hF)) |=> $stable(crc_o));

    // The stored value changes only after a host load or a qualifying request.
    assert_quiet_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!crc_we_i && !imem_req_i && !dmem_req_i) |=> $stable(crc_o));

    // Reset holds the register at zero.
    assert_reset_zero_R7: assert property (@(posedge clk_i)
        !rst_ni |-> crc_o == '0);
endmodule

// File: tb/sim_memload_crc.sv
`timescale 1ns/1ps
module sim_memload_crc;
    localparam time PERIOD = 20ns;

    logic        clk = 1'b0;
    logic        rst_ni = 1'b0;
    logic        core_owns = 1'b0;
    logic        imem_req = 1'b0, dmem_req = 1'b0;
    logic [3:0]  imem_mask = '0, dmem_mask = '0;
    logic [9:0]  imem_idx = '0, dmem_idx = '0;
    logic [31:0] imem_wdata = '0, dmem_wdata = '0;
    logic        crc_we = 1'b0;
    logic [31:0] crc_wdata = '0;
    logic [31:0] crc_o;

    int          checks = 0;
    int          failures = 0;
    logic [31:0] expected = '0;
    string       cur_tag = "R7";

    always #(PERIOD/2) clk = ~clk;

    memload_crc u0 (
        .clk_i(clk), .rst_ni(rst_ni), .core_owns_i(core_owns),
        .imem_req_i(imem_req), .imem_mask_i(imem_mask), .imem_idx_i(imem_idx),
        .imem_wdata_i(imem_wdata), .dmem_req_i(dmem_req), .dmem_mask_i(dmem_mask),
        .dmem_idx_i(dmem_idx), .dmem_wdata_i(dmem_wdata), .crc_we_i(crc_we),
        .crc_wdata_i(crc_wdata), .crc_o(crc_o)
    );

    function automatic logic [31:0] serial_crc(input logic [31:0] c, input logic [47:0] r);
        logic [31:0] v = c;
        for (int b = 0; b < 48; b++) begin
            logic fb = v[0] ^ r[b];
            v = v >> 1;
            if (fb) v = v ^ 32'hEDB88320;
        end
        return v;
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s crc_o actual=%08h expected=%08h", tag, got, exp);
        end
    endtask

    task automatic cyc(input string tag, input logic core,
                       input logic ir, input logic [3:0] im, input logic [9:0] ii, input logic [31:0] id,
                       input logic dr, input logic [3:0] dm, input logic [9:0] di, input logic [31:0] dd,
                       input logic we, input logic [31:0] wd);
        @(negedge clk);
        check(cur_tag, crc_o, expected);
        core_owns = core;
        imem_req = ir; imem_mask = im; imem_idx = ii; imem_wdata = id;
        dmem_req = dr; dmem_mask = dm; dmem_idx = di; dmem_wdata = dd;
        crc_we = we; crc_wdata = wd;
        if (we) begin
            expected = wd;
        end else if (!core && ((ir && im == 4'hF) || (dr && dm == 4'hF))) begin
            if (ir) expected = serial_crc(expected, {1'b1, 5'b0, ii, id});
            else    expected = serial_crc(expected, {1'b0, 5'b0, di, dd});
        end
        cur_tag = tag;
    endtask

    initial begin
        #(PERIOD * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(PERIOD * 2 + 3ns);
        check("R7", crc_o, 32'h0);
        rst_ni = 1'b1;
        // R8: an idle cycle keeps the value
        cyc("R8", 0, 0,4'h0,10'h0,32'h0, 0,4'h0,10'h0,32'h0, 0,32'h0);
        // R1/R2: data-store full write, then instruction-store full write
        cyc("R2", 0, 0,4'h0,10'h0,32'h0, 1,4'hF,10'h123,32'hDEADBEEF, 0,32'h0);
        cyc("R1", 0, 1,4'hF,10'h3FF,32'h01234567, 0,4'h0,10'h0,32'h0, 0,32'h0);
        cyc("R1", 0, 1,4'hF,10'h000,32'h00000000, 0,4'h0,10'h0,32'h0, 0,32'h0);
        cyc("R8", 0, 0,4'h0,10'h0,32'h0, 0,4'h0,10'h0,32'h0, 0,32'h0);
        // R3: partial masks are ignored
        cyc("R3", 0, 1,4'h7,10'h011,32'hAAAA5555, 0,4'h0,10'h0,32'h0, 0,32'h0);
        cyc("R3", 0, 0,4'h0,10'h0,32'h0, 1,4'hE,10'h022,32'h5555AAAA, 0,32'h0);
        cyc("R3", 0, 0,4'h0,10'h0,32'h0, 1,4'h1,10'h022,32'h5555AAAA, 0,32'h0);
        // R4: core ownership blocks full writes
        cyc("R4", 1, 1,4'hF,10'h055,32'hCAFEF00D, 0,4'h0,10'h0,32'h0, 0,32'h0);
        cyc("R4", 1, 0,4'h0,10'h0,32'h0, 1,4'hF,10'h066,32'hF00DCAFE, 0,32'h0);
        // R5: both requesting, instruction side chosen
        cyc("R5", 0, 1,4'hF,10'h101,32'h11112222, 1,4'hF,10'h202,32'h33334444, 0,32'h0);
        cyc("R5", 0, 1,4'h3,10'h0AB,32'h99887766, 1,4'hF,10'h0CD,32'h55443322, 0,32'h0);
        // R6: host load wins over a record, and clearing to zero
        cyc("R6", 0, 1,4'hF,10'h1AA,32'h77777777, 0,4'h0,10'h0,32'h0, 1,32'h89ABCDEF);
        cyc("R6", 0, 0,4'h0,10'h0,32'h0, 1,4'hF,10'h010,32'h12345678, 0,32'h0);
        cyc("R6", 0, 0,4'h0,10'h0,32'h0, 0,4'h0,10'h0,32'h0, 1,32'h0);
        cyc("R2", 0, 0,4'h0,10'h0,32'h0, 1,4'hF,10'h001,32'hFFFFFFFF, 0,32'h0);
        // mixed traffic
        for (int n = 0; n < 400; n++) begin
            logic [31:0] r = $urandom;
            cyc("R2", r[0] & r[1] & r[2],
                r[3], r[4] ? 4'hF : r[8:5], 10'($urandom), $urandom,
                r[9], r[10] ? 4'hF : r[14:11], 10'($urandom), $urandom,
                r[15] & r[16] & r[17], $urandom);
        end
        cyc("R8", 0, 0,4'h0,10'h0,32'h0, 0,4'h0,10'h0,32'h0, 0,32'h0);
        // R7: asynchronous reset away from a clock edge
        @(negedge clk);
        check(cur_tag, crc_o, expected);
        core_owns = 0; imem_req = 0; dmem_req = 0; crc_we = 0;
        if (expected == 32'h0) begin
            crc_we = 1; crc_wdata = 32'h5A5A5A5A; expected = 32'h5A5A5A5A;
            @(negedge clk);
            crc_we = 0;
            check("R6", crc_o, expected);
        end
        #3ns;
        rst_ni = 1'b0;
        #1ns;
        check("R7", crc_o, 32'h0);
        expected = '0;
        @(negedge clk);
        rst_ni = 1'b1;
        cur_tag = "R7";
        cyc("R8", 0, 0,4'h0,10'h0,32'h0, 0,4'h0,10'h0,32'h0, 0,32'h0);
        @(negedge clk);
        check(cur_tag, crc_o, expected);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule